// File: doc/BRIEF.md
# CAN frame field assembler

This block turns one stored transmit message into the serial bit sequence of a CAN frame, from the start-of-frame bit to the last CRC bit. The message is presented on parallel inputs: identifier, format flag, remote flag, data length code and eight data bytes. A start pulse captures it. After that, each bit-time strobe moves the serial output on by one bit. Bit stuffing, bus sampling, acknowledge handling and arbitration are handled by other logic outside this block.

The format flag selects the arbitration layout. A standard frame uses the upper 11 identifier bits. An extended frame uses all 29 identifier bits. The payload is cut to the length the data length code allows, no matter how many data bytes are loaded. A remote frame sends no payload at all. The block computes a CRC-15 over the unstuffed bits while it sends them, and then sends it. Alongside every bit, a field indicator names the frame field that bit belongs to. A done pulse marks the end of the frame.

Top module: `can_frame_assembler`

## Requirements
- R1: After reset, and whenever no frame is in progress, the field indicator reads 0 (idle), the serial output is 1 and done is 0. A bit strobe while idle changes nothing. The field codes are 0 idle, 1 start-of-frame, 2 arbitration, 3 control, 4 data and 5 CRC.
- R2: A start pulse while idle captures the message. In the next cycle the field reads 1 and the output is 0. A start pulse during a frame is ignored, and the frame in progress continues unchanged.
- R3: The output bit and the field indicator change only on the clock edge that samples a bit strobe, and each strobe advances by exactly one bit. A strobe in the same cycle as the start pulse is not counted.
- R4: Standard format (format flag 0) has two parts. The arbitration field is identifier bits 28 down to 18, then the remote flag. The control field then opens with a 0 bit for the format marker.
- R5: Extended format (format flag 1) has an arbitration field of identifier bits 28 down to 18, a 1 bit, another 1 bit, identifier bits 17 down to 0, and then the remote flag.
- R6: The control field is six bits in both formats: two 0 bits, then the 4-bit data length code, most significant bit first.
- R7: Data bytes go out byte 0 first, where byte k sits on msg_data[8k+7:8k], each byte most significant bit first. The number of bytes is the data length code, capped at 8, so codes 9 to 15 send 8 bytes. Bytes beyond that count are never sent.
- R8: When the remote flag is 1, the data field is skipped whatever the data length code is. The CRC follows the control field directly.
- R9: The 15-bit CRC uses polynomial 0x4599 and starts from zero. It covers every bit from start-of-frame through the last data bit and is sent most significant bit first.
- R10: The strobe that ends the last CRC bit raises done for exactly one cycle, and in that same cycle the field returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the message and begin a frame (used only while idle) |
| msg_id | input | 29 | Identifier; standard frames use bits 28:18 |
| msg_ext | input | 1 | Format flag, 1 = extended |
| msg_rtr | input | 1 | Remote flag |
| msg_dlc | input | 4 | Data length code |
| msg_data | input | 64 | Eight data bytes, byte 0 in bits 7:0 |
| bit_tick | input | 1 | Bit-time strobe, one cycle wide |
| tx_bit | output | 1 | Serial output bit, unstuffed |
| field_type | output | 3 | Field of the current bit (codes in R1) |
| done | output | 1 | One-cycle pulse after the final CRC bit |

## Verification
The bench builds the block with its default parameters: a 29-bit identifier whose upper 11 bits form the base, a 4-bit length code, eight data bytes, and a CRC-15 with polynomial 0x4599. Because the length code is 4 bits and the data store is 8 bytes, the codes 9 to 15 are in reach, so the clipping path runs alongside the normal lengths 0, 2, 3 and 8. The same settings give both arbitration layouts, 12 and 32 bits long, so one run covers the shortest frame (34 bits) and the longest (118 bits), with remote frames and oversized length codes included.

// File: rtl/can_fa_pkg.sv
package can_fa_pkg;

    // Field indicator codes presented on field_type
    typedef enum logic [2:0] {
        FLD_IDLE = 3'd0,
        FLD_SOF  = 3'd1,
        FLD_ARB  = 3'd2,
        FLD_CTRL = 3'd3,
        FLD_DATA = 3'd4,
        FLD_CRC  = 3'd5
    } fld_e;

endpackage

// File: rtl/can_fa_crc_step.sv
// One serial step of a CRC shift register.
module can_fa_crc_step #(
    parameter int                CRC_W = 15,
    parameter logic [CRC_W-1:0]  POLY  = 15'h4599
) (
    input  logic [CRC_W-1:0] crc_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);
    logic feedback;

    always_comb begin
        feedback = bit_i ^ crc_i[CRC_W-1];
        crc_o    = {crc_i[CRC_W-2:0], 1'b0} ^ (feedback ? POLY : '0);
    end
endmodule

// File: rtl/can_fa_field_mux.sv
// Picks the bit for the current field and position, and flags the last bit of the field.
module can_fa_field_mux
    import can_fa_pkg::*;
#(
    parameter int ID_W      = 29,
    parameter int BASE_W    = 11,
    parameter int DLC_W     = 4,
    parameter int MAX_BYTES = 8,
    parameter int CRC_W     = 15,
    parameter int IDX_W     = 6,
    parameter int CNT_W     = 7
) (
    input  fld_e                   field_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic [ID_W-1:0]        id_i,
    input  logic                   ext_i,
    input  logic                   rtr_i,
    input  logic [DLC_W-1:0]       dlc_i,
    input  logic [MAX_BYTES*8-1:0] data_i,
    input  logic [CRC_W-1:0]       crc_i,
    input  logic [CNT_W-1:0]       nbits_i,
    output logic                   bit_o,
    output logic                   last_o
);
    localparam int EXT_W     = ID_W - BASE_W;
    localparam int ID_SEL_W  = $clog2(ID_W);
    localparam int DAT_SEL_W = $clog2(MAX_BYTES * 8);
    localparam int CRC_SEL_W = $clog2(CRC_W);
    localparam int DLC_SEL_W = $clog2(DLC_W);

    int                   pos;
    logic [ID_SEL_W-1:0]  id_sel;
    logic [DAT_SEL_W-1:0] dat_sel;
    logic [CRC_SEL_W-1:0] crc_sel;
    logic [DLC_SEL_W-1:0] dlc_sel;

    always_comb begin
        pos     = int'(idx_i);
        bit_o   = 1'b1;
        last_o  = 1'b0;
        id_sel  = '0;
        dat_sel = '0;
        crc_sel = '0;
        dlc_sel = '0;
        case (field_i)
            FLD_SOF: begin
                bit_o  = 1'b0;
                last_o = 1'b1;
            end
            FLD_ARB: begin
                if (pos < BASE_W) begin
                    id_sel = ID_SEL_W'(ID_W - 1 - pos);
                    bit_o  = id_i[id_sel];
                end else if (!ext_i) begin
                    bit_o  = rtr_i;
                    last_o = 1'b1;
                end else if (pos == BASE_W || pos == BASE_W + 1) begin
                    bit_o  = 1'b1;          // substitute-remote and format marker
                end else if (pos < BASE_W + 2 + EXT_W) begin
                    id_sel = ID_SEL_W'(EXT_W - 1 - (pos - BASE_W - 2));
                    bit_o  = id_i[id_sel];
                end else begin
                    bit_o  = rtr_i;
                    last_o = 1'b1;
                end
            end
            FLD_CTRL: begin
                if (pos < 2) begin
                    bit_o = 1'b0;           // format marker / reserved bits
                end else begin
                    dlc_sel = DLC_SEL_W'(DLC_W + 1 - pos);
                    bit_o   = dlc_i[dlc_sel];
                end
                last_o = (pos == DLC_W + 1);
            end
            FLD_DATA: begin
                dat_sel = DAT_SEL_W'((pos / 8) * 8 + 7 - (pos % 8));
                bit_o   = data_i[dat_sel];
                last_o  = (pos == int'(nbits_i) - 1);
            end
            FLD_CRC: begin
                crc_sel = CRC_SEL_W'(CRC_W - 1 - pos);
                bit_o   = crc_i[crc_sel];
                last_o  = (pos == CRC_W - 1);
            end
            default: begin
                bit_o  = 1'b1;
                last_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/can_frame_assembler.sv
module can_frame_assembler
    import can_fa_pkg::*;
#(
    parameter int               ID_W      = 29,
    parameter int               BASE_W    = 11,
    parameter int               DLC_W     = 4,
    parameter int               MAX_BYTES = 8,
    parameter int               CRC_W     = 15,
    parameter logic [CRC_W-1:0] CRC_POLY  = 15'h4599
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [ID_W-1:0]        msg_id,
    input  logic                   msg_ext,
    input  logic                   msg_rtr,
    input  logic [DLC_W-1:0]       msg_dlc,
    input  logic [MAX_BYTES*8-1:0] msg_data,
    input  logic                   bit_tick,
    output logic                   tx_bit,
    output logic [2:0]             field_type,
    output logic                   done
);
    localparam int DATA_BITS = MAX_BYTES * 8;
    localparam int ARB_MAX   = ID_W + 3;
    localparam int SPAN_A    = (DATA_BITS > ARB_MAX) ? DATA_BITS : ARB_MAX;
    localparam int SPAN      = (SPAN_A > CRC_W) ? SPAN_A : CRC_W;
    localparam int IDX_W     = $clog2(SPAN);
    localparam int CNT_W     = $clog2(DATA_BITS + 1);

    typedef struct packed {
        fld_e                  field;
        logic [IDX_W-1:0]      idx;
        logic [CRC_W-1:0]      crc;
        logic [ID_W-1:0]       id;
        logic                  ext;
        logic                  rtr;
        logic [DLC_W-1:0]      dlc;
        logic [DATA_BITS-1:0]  data;
        logic                  done;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] nbits;
    logic             cur_bit;
    logic             last_bit;
    logic [CRC_W-1:0] crc_nxt;

    // Payload length in bits: remote frames carry none, codes above the byte count clip
    always_comb begin
        if (st_q.rtr)
            nbits = '0;
        else if (int'(st_q.dlc) > MAX_BYTES)
            nbits = CNT_W'(DATA_BITS);
        else
            nbits = CNT_W'(int'(st_q.dlc) * 8);
    end

    can_fa_field_mux #(
        .ID_W      (ID_W),
        .BASE_W    (BASE_W),
        .DLC_W     (DLC_W),
        .MAX_BYTES (MAX_BYTES),
        .CRC_W     (CRC_W),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) mux_i (
        .field_i (st_q.field),
        .idx_i   (st_q.idx),
        .id_i    (st_q.id),
        .ext_i   (st_q.ext),
        .rtr_i   (st_q.rtr),
        .dlc_i   (st_q.dlc),
        .data_i  (st_q.data),
        .crc_i   (st_q.crc),
        .nbits_i (nbits),
        .bit_o   (cur_bit),
        .last_o  (last_bit)
    );

    can_fa_crc_step #(
        .CRC_W (CRC_W),
        .POLY  (CRC_POLY)
    ) crc_i (
        .crc_i (st_q.crc),
        .bit_i (cur_bit),
        .crc_o (crc_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.field == FLD_IDLE) begin
            if (start) begin
                st_d.field = FLD_SOF;
                st_d.idx   = '0;
                st_d.crc   = '0;
                st_d.id    = msg_id;
                st_d.ext   = msg_ext;
                st_d.rtr   = msg_rtr;
                st_d.dlc   = msg_dlc;
                st_d.data  = msg_data;
            end
        end else if (bit_tick) begin
            if (st_q.field != FLD_CRC)
                st_d.crc = crc_nxt;
            if (last_bit) begin
                st_d.idx = '0;
                case (st_q.field)
                    FLD_SOF:  st_d.field = FLD_ARB;
                    FLD_ARB:  st_d.field = FLD_CTRL;
                    FLD_CTRL: st_d.field = (nbits != '0) ? FLD_DATA : FLD_CRC;
                    FLD_DATA: st_d.field = FLD_CRC;
                    default: begin
                        st_d.field = FLD_IDLE;
                        st_d.done  = 1'b1;
                    end
                endcase
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.field <= FLD_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_bit     = cur_bit;
    assign field_type = st_q.field;
    assign done       = st_q.done;

    // Idle line is recessive
    p_idle_recessive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.field == FLD_IDLE) |-> tx_bit);

    // Without a start, idle stays idle even when strobes arrive
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.field == FLD_IDLE && !start) |=> (st_q.field == FLD_IDLE));

    p_start_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.field == FLD_IDLE && start) |=> (field_type == 3'd1 && !tx_bit));

    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.field != FLD_IDLE && !bit_tick) |=> ($stable(tx_bit) && $stable(field_type)));

    p_std_marker_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.field == FLD_CTRL && !st_q.ext && st_q.idx == '0) |-> !tx_bit);

    p_ext_markers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.field == FLD_ARB && st_q.ext &&
         (int'(st_q.idx) == BASE_W || int'(st_q.idx) == BASE_W + 1)) |-> tx_bit);

    p_ctrl_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.field == FLD_CTRL && int'(st_q.idx) < 2) |-> !tx_bit);

    p_payload_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.field == FLD_DATA) |-> (int'(st_q.idx) < int'(nbits)));

    p_remote_nodata_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.field == FLD_DATA) |-> !st_q.rtr);

    p_crc_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.field == FLD_CRC) |=> (st_q.field != FLD_CRC || $stable(st_q.crc)));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st_q.field == FLD_CRC && bit_tick) && field_type == 3'd0));

endmodule

// File: tb/can_frame_assembler_tb.sv
module can_frame_assembler_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [28:0] msg_id = '0;
    logic        msg_ext = 1'b0;
    logic        msg_rtr = 1'b0;
    logic [3:0]  msg_dlc = '0;
    logic [63:0] msg_data = '0;
    logic        bit_tick = 1'b0;
    logic        tx_bit;
    logic [2:0]  field_type;
    logic        done;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    logic       exp_b [0:199];
    logic [2:0] exp_f [0:199];
    int         exp_len;

    always #10 clk = ~clk;   // 50 MHz

    can_frame_assembler dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .msg_id     (msg_id),
        .msg_ext    (msg_ext),
        .msg_rtr    (msg_rtr),
        .msg_dlc    (msg_dlc),
        .msg_data   (msg_data),
        .bit_tick   (bit_tick),
        .tx_bit     (tx_bit),
        .field_type (field_type),
        .done       (done)
    );

    // Vector: {id[28:0], ext, rtr, dlc[3:0], data[63:0]}; gap = idle cycles between strobes
    localparam int NVEC = 8;
    localparam logic [98:0] VECS [0:NVEC-1] = '{
        {29'h048C_3FFF, 1'b0, 1'b0, 4'd2,  64'h0000_0000_0000_A55A},
        {29'h1ABC_DEF1, 1'b1, 1'b0, 4'd8,  64'h0123_4567_89AB_CDEF},
        {29'h0000_0000, 1'b0, 1'b0, 4'd0,  64'hFFFF_FFFF_FFFF_FFFF},
        {29'h1555_5555, 1'b0, 1'b1, 4'd4,  64'h1122_3344_5566_7788},
        {29'h0AAA_AAAA, 1'b0, 1'b0, 4'd12, 64'hDEAD_BEEF_CAFE_F00D},
        {29'h1FFF_FFFF, 1'b1, 1'b1, 4'd8,  64'h0000_0000_0000_0000},
        {29'h0246_8ACE, 1'b1, 1'b0, 4'd3,  64'hFFFF_FFFF_FFFF_FFFF},
        {29'h1FFF_FFFF, 1'b0, 1'b0, 4'd15, 64'h8040_2010_0804_0201}
    };
    localparam int GAPS [0:NVEC-1] = '{0, 1, 2, 0, 1, 0, 2, 1};

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic put(input logic b, input logic [2:0] f);
        exp_b[exp_len] = b;
        exp_f[exp_len] = f;
        exp_len++;
    endtask

    // Expected frame built from the requirements
    task automatic build_exp(input logic [98:0] v);
        logic [28:0] id;
        logic        ext, rtr;
        logic [3:0]  dlc;
        logic [63:0] dat;
        logic [14:0] crc;
        logic        fb;
        int          nb;
        id = v[98:70]; ext = v[69]; rtr = v[68]; dlc = v[67:64]; dat = v[63:0];
        exp_len = 0;
        put(1'b0, 3'd1);                                      // R2 start-of-frame
        for (int i = 28; i >= 18; i--) put(id[i], 3'd2);
        if (ext) begin                                        // R5
            put(1'b1, 3'd2);
            put(1'b1, 3'd2);
            for (int i = 17; i >= 0; i--) put(id[i], 3'd2);
            put(rtr, 3'd2);
        end else begin                                        // R4
            put(rtr, 3'd2);
        end
        put(1'b0, 3'd3);                                      // R6
        put(1'b0, 3'd3);
        for (int i = 3; i >= 0; i--) put(dlc[i], 3'd3);
        nb = rtr ? 0 : ((int'(dlc) > 8) ? 8 : int'(dlc));     // R7, R8
        for (int b = 0; b < nb; b++)
            for (int i = 7; i >= 0; i--) put(dat[b*8+i], 3'd4);
        crc = '0;                                             // R9
        for (int j = 0; j < exp_len; j++) begin
            fb  = exp_b[j] ^ crc[14];
            crc = {crc[13:0], 1'b0};
            if (fb) crc = crc ^ 15'h4599;
        end
        for (int i = 14; i >= 0; i--) put(crc[i], 3'd5);
    endtask

    function automatic string req_of(input logic [2:0] f, input logic ext);
        case (f)
            3'd1: return "R2";
            3'd2: return ext ? "R5" : "R4";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic run_frame(input logic [98:0] v, input int gap,
                             input bit inject, input bit tick_at_start);
        int first_k, bad, stab_bad, inj_bad, dcount, done_mid, exp_d;
        int act_v, exp_v;
        build_exp(v);
        @(negedge clk);
        msg_id = v[98:70]; msg_ext = v[69]; msg_rtr = v[68];
        msg_dlc = v[67:64]; msg_data = v[63:0];
        start = 1'b1;
        bit_tick = tick_at_start;
        @(negedge clk);
        start = 1'b0;
        bit_tick = 1'b0;
        first_k = -1; bad = 0; stab_bad = 0; inj_bad = 0; dcount = 0; done_mid = 0;
        act_v = 0; exp_v = 0;
        for (int k = 0; k < exp_len; k++) begin
            if (tx_bit !== exp_b[k] || field_type !== exp_f[k]) begin
                bad++;
                if (first_k < 0) begin
                    first_k = k;
                    act_v = {field_type, tx_bit};
                    exp_v = {exp_f[k], exp_b[k]};
                end
            end
            if (field_type == 3'd4) dcount++;
            if (done) done_mid++;
            if (inject && k == 5) begin
                start = 1'b1;                                 // R2 start while busy
                msg_id = ~msg_id; msg_ext = ~msg_ext; msg_dlc = ~msg_dlc; msg_data = ~msg_data;
                @(negedge clk);
                start = 1'b0;
                if (tx_bit !== exp_b[k] || field_type !== exp_f[k]) inj_bad++;
            end
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                if (tx_bit !== exp_b[k] || field_type !== exp_f[k]) stab_bad++;
            end
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
        if (first_k >= 0)
            check(1'b0, req_of(exp_f[first_k], v[69]),
                  $sformatf("frame bit %0d {field,bit}", first_k), act_v, exp_v);
        else
            check(1'b1, "R9", "frame bits", 0, 0);
        check(stab_bad == 0, "R3", "changes without strobe", stab_bad, 0);
        exp_d = v[68] ? 0 : ((int'(v[67:64]) > 8) ? 64 : int'(v[67:64]) * 8);
        check(dcount == exp_d, v[68] ? "R8" : "R7", "data bits sent", dcount, exp_d);
        if (inject) check(inj_bad == 0 && bad == 0, "R2", "start during frame", inj_bad + bad, 0);
        check(done === 1'b1 && field_type === 3'd0 && tx_bit === 1'b1 && done_mid == 0,
              "R10", "done after last CRC bit", {done_mid[3:0], done, field_type}, 8);
        @(negedge clk);
        check(done === 1'b0, "R10", "done single cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL R10 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(field_type === 3'd0 && tx_bit === 1'b1 && done === 1'b0, "R1",
              "state in reset", {field_type, tx_bit, done}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        check(field_type === 3'd0 && tx_bit === 1'b1 && done === 1'b0, "R1",
              "state after reset", {field_type, tx_bit, done}, 2);

        // R1 strobes while idle have no effect
        bit_tick = 1'b1;
        repeat (4) @(negedge clk);
        bit_tick = 1'b0;
        check(field_type === 3'd0 && tx_bit === 1'b1 && done === 1'b0, "R1",
              "strobe while idle", {field_type, tx_bit, done}, 2);

        // Table of vectors
        for (int n = 0; n < NVEC; n++)
            run_frame(VECS[n], GAPS[n], 1'b0, 1'b0);

        // R3 strobe in the start cycle is not counted; R2 start during frame ignored
        run_frame(VECS[1], 0, 1'b1, 1'b1);
        run_frame(VECS[0], 1, 1'b1, 1'b0);

        // R7 clipping: oversized length code with full data
        run_frame({29'h1234_5678, 1'b1, 1'b0, 4'd9, 64'hA5A5_5A5A_0F0F_F0F0}, 0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule